// File: doc/BRIEF.md
# Bit-Serial Mesh Processing Cell

This block is one single-bit processing element of a mesh-connected image array. Eight neighbour bits arrive at the cell, and each one has its own enable. The enabled bits are ORed into one merged signal. Two operand registers, A and B, are loaded from a small local bit memory. A two-input Boolean unit drives two outputs. The first is the result bit, which can be written back into local memory. The second is a bit that goes out to the neighbours.

In logic mode the Boolean unit sees the merged neighbour signal ORed with B, together with A. It applies two independent four-entry truth tables, one for each output. In add mode the front stage becomes a half adder. The controller programs the Boolean unit as a second half adder (XOR table for the result, AND table for the neighbour output), so the cell acts as a full adder. A carry register holds the carry from one bit cycle to the next. A carry-source select picks where the incoming carry comes from: the carry register, for plain bit-serial addition of two bit-planes, or the merged neighbour signal, for column-wise addition where the carry ripples from cell to cell.

An external sequencer issues one control word per cycle. Multi-bit additions are built from these words, one bit per cycle, least significant bit first.

Top module: `pebs_cell`

## Requirements
- R1: After synchronous reset, A, B and the carry register C are 0, and every local memory bit is 0.
- R2: The merged neighbour signal T is the OR over all neighbours of (nbr_in[i] AND nbr_en[i]). A neighbour whose enable is 0 has no effect on any output.
- R3: In logic mode (add_mode = 0), the Boolean unit input P equals B OR T.
- R4: The Boolean unit forms index {P, A}, with P as the high bit. d_out = tbl_d[index] and nbr_out = tbl_n[index]. For example, 4'b1010 passes A, 4'b1100 passes P, 4'b0110 is XOR and 4'b1000 is AND.
- R5: When wr_en = 1, bit wr_addr of local memory takes d_out at the clock edge. When ld_a (ld_b) = 1, A (B) takes the memory bit at addr_a (addr_b) as it was before that same edge, and it is visible in the next cycle.
- R6: In add mode, P = B XOR X and the first-stage carry is B AND X. X is C when carry_src = 0, and T when carry_src = 1.
- R7: In add mode with tbl_d = 4'b0110 and tbl_n = 4'b1000, d_out = A XOR B XOR X, and carry_out is the majority of A, B and X.
- R8: c_clr clears C at the edge and takes priority. Otherwise, in add mode C takes carry_out at each edge, and in logic mode C holds its value.
- R9: With carry_src = 1, carry_out gives the carry toward the next cell of a column, computed from the incoming neighbour carry T.
- R10: An 8-bit addition of operands stored least significant bit first takes one clear-and-load cycle and then eight add cycles. Each add cycle writes one sum bit to consecutive addresses. The ninth sum bit is left in C (c_q).
- R11: In logic mode, carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nbr_in | input | 8 | Neighbour data bits |
| nbr_en | input | 8 | Per-neighbour enable |
| add_mode | input | 1 | 1 = adder datapath, 0 = logic datapath |
| carry_src | input | 1 | Add-mode carry source: 0 = C register, 1 = merged neighbour signal |
| c_clr | input | 1 | Clear carry register |
| tbl_d | input | 4 | Truth table for the result bit |
| tbl_n | input | 4 | Truth table for the neighbour output |
| addr_a | input | 5 | Memory address loaded into A |
| ld_a | input | 1 | Load A |
| addr_b | input | 5 | Memory address loaded into B |
| ld_b | input | 1 | Load B |
| wr_addr | input | 5 | Memory write address |
| wr_en | input | 1 | Write d_out to memory |
| d_out | output | 1 | Result bit |
| nbr_out | output | 1 | Bit sent to neighbours |
| carry_out | output | 1 | Full-adder carry in add mode, 0 otherwise |
| c_q | output | 1 | Carry register |

## Verification
d_out, nbr_out and carry_out are combinational functions of the present controls and of the A, B and C registers. They are therefore due in the same cycle their controls are applied. Register loads, memory writes and carry updates appear only one cycle later. The bench applies each control word just after a falling edge and pushes the expectation for that same cycle into a queue. A monitor pops and compares it shortly before the next rising edge. The bench model advances its own A, B, C and memory only after that comparison point. As a result, a memory bit written in one cycle is checked only after a later load brings it back into A.

// File: rtl/pebs_pkg.sv
package pebs_pkg;

    typedef enum logic {
        CSRC_REG = 1'b0,
        CSRC_NBR = 1'b1
    } carry_src_e;

    typedef struct packed {
        logic [3:0] d_tbl;
        logic [3:0] n_tbl;
    } bool_cfg_t;

    typedef struct packed {
        logic sum;
        logic carry;
    } ha_t;

    function automatic ha_t half_add(input logic x, input logic y);
        ha_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

    function automatic logic lut2(input logic [3:0] tbl, input logic p, input logic a);
        return tbl[{p, a}];
    endfunction

endpackage

// File: rtl/pebs_nbr_merge.sv
module pebs_nbr_merge #(
    parameter int NBR_N = 8
) (
    input  logic [NBR_N-1:0] nbr_in,
    input  logic [NBR_N-1:0] nbr_en,
    output logic             t_out
);
    logic [NBR_N-1:0] gated;

    for (genvar i = 0; i < NBR_N; i++) begin : g_gate
        assign gated[i] = nbr_in[i] & nbr_en[i];
    end

    assign t_out = |gated;
endmodule

// File: rtl/pebs_front.sv
module pebs_front
    import pebs_pkg::*;
(
    input  logic       add_mode,
    input  carry_src_e csrc,
    input  logic       b_q,
    input  logic       t_in,
    input  logic       c_q,
    output logic       p_out,
    output logic       h_carry
);
    logic x_in;
    ha_t  ha;

    always_comb begin
        x_in = (csrc == CSRC_NBR) ? t_in : c_q;
        ha   = half_add(b_q, x_in);
        if (add_mode) begin
            p_out   = ha.sum;
            h_carry = ha.carry;
        end else begin
            p_out   = b_q | t_in;
            h_carry = 1'b0;
        end
    end
endmodule

// File: rtl/pebs_bool_unit.sv
module pebs_bool_unit
    import pebs_pkg::*;
(
    input  bool_cfg_t cfg,
    input  logic      p_in,
    input  logic      a_in,
    output logic      d_out,
    output logic      n_out
);
    always_comb begin
        d_out = lut2(cfg.d_tbl, p_in, a_in);
        n_out = lut2(cfg.n_tbl, p_in, a_in);
    end
endmodule

// File: rtl/pebs_mem.sv
module pebs_mem #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              rd_a,
    output logic              rd_b
);
    logic [DEPTH-1:0] bits_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                bits_q[i] <= wr_data;
        end
    end

    assign rd_a = bits_q[addr_a];
    assign rd_b = bits_q[addr_b];
endmodule

// File: rtl/pebs_cell.sv
module pebs_cell
    import pebs_pkg::*;
#(
    parameter int NBR_N     = 8,
    parameter int MEM_DEPTH = 32,
    parameter int TBL_W     = 4,
    localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBR_N-1:0]  nbr_in,
    input  logic [NBR_N-1:0]  nbr_en,
    input  logic              add_mode,
    input  logic              carry_src,
    input  logic              c_clr,
    input  logic [TBL_W-1:0]  tbl_d,
    input  logic [TBL_W-1:0]  tbl_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              ld_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              ld_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    output logic              d_out,
    output logic              nbr_out,
    output logic              carry_out,
    output logic              c_q
);
    logic      a_q, b_q, c_r;
    logic      t_sig, p_sig, h_carry, rd_a, rd_b, full_carry;
    bool_cfg_t cfg;
    carry_src_e csrc;

    assign cfg  = '{d_tbl: tbl_d, n_tbl: tbl_n};
    assign csrc = carry_src_e'(carry_src);

    pebs_nbr_merge #(.NBR_N(NBR_N)) u_merge (
        .nbr_in (nbr_in),
        .nbr_en (nbr_en),
        .t_out  (t_sig)
    );

    pebs_front u_front (
        .add_mode (add_mode),
        .csrc     (csrc),
        .b_q      (b_q),
        .t_in     (t_sig),
        .c_q      (c_r),
        .p_out    (p_sig),
        .h_carry  (h_carry)
    );

    pebs_bool_unit u_bool (
        .cfg   (cfg),
        .p_in  (p_sig),
        .a_in  (a_q),
        .d_out (d_out),
        .n_out (nbr_out)
    );

    pebs_mem #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (d_out),
        .addr_a  (addr_a),
        .addr_b  (addr_b),
        .rd_a    (rd_a),
        .rd_b    (rd_b)
    );

    assign full_carry = h_carry | nbr_out;
    assign carry_out  = add_mode & full_carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
            c_r <= 1'b0;
        end else begin
            if (ld_a) a_q <= rd_a;
            if (ld_b) b_q <= rd_b;
            if (c_clr)         c_r <= 1'b0;
            else if (add_mode) c_r <= full_carry;
        end
    end

    assign c_q = c_r;
endmodule

// File: rtl/pebs_cell_chk.sv
module pebs_cell_chk (
    input logic       clk,
    input logic       rst,
    input logic       add_mode,
    input logic       carry_src,
    input logic       c_clr,
    input logic [3:0] tbl_d,
    input logic [3:0] tbl_n,
    input logic       a_q,
    input logic       b_q,
    input logic       d_out,
    input logic       carry_out,
    input logic       c_q
);
    assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (c_q == 1'b0));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        c_clr |=> (c_q == 1'b0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!add_mode && !c_clr) |=> $stable(c_q));

    assert_update_R8: assert property (@(posedge clk) disable iff (rst)
        (add_mode && !c_clr) |=> (c_q == $past(carry_out)));

    assert_no_carry_R11: assert property (@(posedge clk) disable iff (rst)
        !add_mode |-> (carry_out == 1'b0));

    assert_full_sum_R7: assert property (@(posedge clk) disable iff (rst)
        (add_mode && !carry_src && tbl_d == 4'b0110 && tbl_n == 4'b1000)
        |-> (d_out == (a_q ^ b_q ^ c_q)));
endmodule

bind pebs_cell pebs_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .add_mode  (add_mode),
    .carry_src (carry_src),
    .c_clr     (c_clr),
    .tbl_d     (tbl_d),
    .tbl_n     (tbl_n),
    .a_q       (a_q),
    .b_q       (b_q),
    .d_out     (d_out),
    .carry_out (carry_out),
    .c_q       (c_q)
);

// File: tb/pebs_cell_bench.sv
`timescale 1ns/1ps
module pebs_cell_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] nbr_in = '0, nbr_en = '0;
    logic       add_mode = 0, carry_src = 0, c_clr = 0;
    logic [3:0] tbl_d = '0, tbl_n = '0;
    logic [4:0] addr_a = '0, addr_b = '0, wr_addr = '0;
    logic       ld_a = 0, ld_b = 0, wr_en = 0;
    logic       d_out, nbr_out, carry_out, c_q;

    always #2.5 clk = ~clk;

    pebs_cell u_pebs_cell (
        .clk(clk), .rst(rst), .nbr_in(nbr_in), .nbr_en(nbr_en),
        .add_mode(add_mode), .carry_src(carry_src), .c_clr(c_clr),
        .tbl_d(tbl_d), .tbl_n(tbl_n), .addr_a(addr_a), .ld_a(ld_a),
        .addr_b(addr_b), .ld_b(ld_b), .wr_addr(wr_addr), .wr_en(wr_en),
        .d_out(d_out), .nbr_out(nbr_out), .carry_out(carry_out), .c_q(c_q)
    );

    typedef struct {
        logic [7:0] nin, nen;
        logic       add, src, clr;
        logic [3:0] td, tn;
        logic [4:0] aa, ba, wa;
        logic       la, lb, we;
    } ctl_t;

    typedef struct {
        logic  d, n, cy, c;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0, n_bad = 0;
    bit   done = 0;

    // bench model state
    bit       mA = 0, mB = 0, mC = 0;
    bit [31:0] mmem = '0;

    function automatic ctl_t idle();
        ctl_t c;
        c.nin = '0; c.nen = '0; c.add = 0; c.src = 0; c.clr = 0;
        c.td = '0; c.tn = '0; c.aa = '0; c.ba = '0; c.wa = '0;
        c.la = 0; c.lb = 0; c.we = 0;
        return c;
    endfunction

    // ovr: 0 none, 1 override d, 2 override c
    task automatic step(input ctl_t c, input string tag, input int ovr, input bit ov);
        exp_t e;
        bit t, x, p, h, d, n, cy, ra, rb;
        @(negedge clk);
        nbr_in = c.nin; nbr_en = c.nen; add_mode = c.add; carry_src = c.src;
        c_clr = c.clr; tbl_d = c.td; tbl_n = c.tn; addr_a = c.aa; ld_a = c.la;
        addr_b = c.ba; ld_b = c.lb; wr_addr = c.wa; wr_en = c.we;
        t = |(c.nin & c.nen);
        x = c.src ? t : mC;
        if (c.add) begin p = mB ^ x; h = mB & x; end
        else       begin p = mB | t; h = 0; end
        d  = c.td[{p, mA}];
        n  = c.tn[{p, mA}];
        cy = c.add ? (h | n) : 1'b0;
        e.d = d; e.n = n; e.cy = cy; e.c = mC; e.tag = tag;
        if (ovr == 1) e.d = ov;
        if (ovr == 2) e.c = ov;
        q.push_back(e);
        ra = mmem[c.aa]; rb = mmem[c.ba];
        if (c.we) mmem[c.wa] = d;
        if (c.la) mA = ra;
        if (c.lb) mB = rb;
        if (c.clr) mC = 0;
        else if (c.add) mC = cy;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (d_out !== e.d || nbr_out !== e.n || carry_out !== e.cy || c_q !== e.c) begin
                    n_bad++;
                    $display("FAIL %s: got d=%b n=%b cy=%b c=%b, expected d=%b n=%b cy=%b c=%b",
                             e.tag, d_out, nbr_out, carry_out, c_q, e.d, e.n, e.cy, e.c);
                end
            end
        end
    end

    task automatic wr_bit(input int addr, input bit v);
        ctl_t c = idle();
        c.td = v ? 4'hF : 4'h0; c.we = 1; c.wa = 5'(addr);
        step(c, "R5 write constant", 0, 0);
    endtask

    task automatic add8(input logic [7:0] xv, input logic [7:0] yv);
        ctl_t c;
        logic [8:0] s = {1'b0, xv} + {1'b0, yv};
        for (int k = 0; k < 8; k++) begin
            wr_bit(k, xv[k]);
            wr_bit(8 + k, yv[k]);
        end
        c = idle(); c.la = 1; c.lb = 1; c.aa = 0; c.ba = 8; c.clr = 1;
        step(c, "R10 clear and load", 0, 0);
        for (int k = 0; k < 8; k++) begin
            c = idle(); c.add = 1; c.td = 4'b0110; c.tn = 4'b1000;
            c.we = 1; c.wa = 5'(16 + k);
            if (k < 7) begin c.la = 1; c.lb = 1; c.aa = 5'(k + 1); c.ba = 5'(9 + k); end
            step(c, "R10 R7 add bit", 0, 0);
        end
        c = idle(); c.la = 1; c.aa = 16;
        step(c, "R10 final carry in c_q", 2, s[8]);
        for (int k = 0; k < 8; k++) begin
            c = idle(); c.td = 4'b1010;
            if (k < 7) begin c.la = 1; c.aa = 5'(17 + k); end
            step(c, "R10 sum bit readback", 1, s[k]);
        end
    endtask

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        ctl_t c;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, memory read back as zero
        c = idle(); c.td = 4'b1010; c.la = 1; c.aa = 5;
        step(c, "R1 reset registers", 0, 0);
        c = idle(); c.td = 4'b1010;
        step(c, "R1 reset memory bit", 1, 1'b0);

        // operands for logic tests: mem30=0, mem31=1
        wr_bit(30, 0); wr_bit(31, 1);
        c = idle(); c.la = 1; c.aa = 31; c.lb = 1; c.ba = 30;
        step(c, "R5 load A=1 B=0", 0, 0);
        // R2/R3 gating and OR with B
        c = idle(); c.td = 4'b1100; c.nin = 8'hFF; c.nen = 8'h00;
        step(c, "R2 all disabled", 1, 1'b0);
        c = idle(); c.td = 4'b1100; c.nin = 8'h10; c.nen = 8'h10;
        step(c, "R2 R3 one enabled", 1, 1'b1);
        c = idle(); c.td = 4'b1100; c.nin = 8'hEF; c.nen = 8'h10;
        step(c, "R2 others ignored", 1, 1'b0);
        c = idle(); c.td = 4'b1100; c.nin = 8'h81; c.nen = 8'h80;
        step(c, "R2 top neighbour", 1, 1'b1);
        // R4 truth tables
        c = idle(); c.td = 4'b1000; c.tn = 4'b0110;
        step(c, "R4 AND/XOR P=0 A=1", 0, 0);
        c = idle(); c.td = 4'b1000; c.tn = 4'b0110; c.nin = 8'h02; c.nen = 8'h02;
        step(c, "R4 AND/XOR P=1 A=1", 0, 0);
        c = idle(); c.td = 4'b0001; c.tn = 4'b0100; c.lb = 1; c.ba = 31; c.la = 1; c.aa = 30;
        step(c, "R4 NOR/table", 0, 0);
        c = idle(); c.td = 4'b1100; c.tn = 4'b0100;
        step(c, "R3 B=1 forces P", 1, 1'b1);

        // serial additions R10 R7 R8
        add8(8'hB7, 8'h5C);
        add8(8'hFF, 8'h01);
        add8(8'h12, 8'h34);

        // R11 logic mode after an add leaving C=1: C holds, carry_out 0
        add8(8'h80, 8'h80);
        c = idle(); c.td = 4'hF; c.tn = 4'hF; c.nin = 8'hFF; c.nen = 8'hFF;
        step(c, "R11 R8 logic hold", 2, 1'b1);
        c = idle(); c.td = 4'h0;
        step(c, "R11 R8 still held", 2, 1'b1);

        // R6 first half adder alone: P = B ^ C, A=0 via pass P table
        wr_bit(29, 1);
        c = idle(); c.la = 1; c.aa = 30; c.lb = 1; c.ba = 29;
        step(c, "R5 load A=0 B=1", 0, 0);
        c = idle(); c.add = 1; c.td = 4'b1100; c.tn = 4'b0000;
        step(c, "R6 P=B^C with C=1", 1, 1'b0);
        c = idle(); c.add = 1; c.td = 4'b1100; c.clr = 1;
        step(c, "R6 R8 clear priority", 0, 0);
        c = idle(); c.td = 4'b1100;
        step(c, "R8 cleared", 2, 1'b0);

        // R9 column carry from neighbour
        c = idle(); c.add = 1; c.src = 1; c.td = 4'b0110; c.tn = 4'b1000;
        c.nin = 8'h04; c.nen = 8'h04;
        step(c, "R9 T=1 B=1 A=0", 0, 0);
        c.nin = 8'h00;
        step(c, "R9 T=0 B=1 A=0", 0, 0);
        c.nin = 8'h04; c.nen = 8'h00;
        step(c, "R9 R2 disabled carry", 0, 0);
        c = idle(); c.la = 1; c.aa = 29; c.lb = 1; c.ba = 30;
        step(c, "R5 load A=1 B=0", 0, 0);
        c = idle(); c.add = 1; c.src = 1; c.td = 4'b0110; c.tn = 4'b1000;
        c.nin = 8'h04; c.nen = 8'h04;
        step(c, "R9 T=1 B=0 A=1", 0, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule